// File: doc/BRIEF.md
# Bus Load Monitor Channel

This block watches one source of bus activity and turns it into interrupt requests for a frequency-scaling governor. Each pulse on the activity input adds a programmable weight to a per-period accumulator. A millisecond tick input drives a sampling timer. When a period ends, the accumulated count becomes the period's sample, and the accumulator starts again from zero. The sample feeds a shift-based exponential moving average, which software may seed before sampling starts.

Two kinds of condition set sticky interrupt flags. The first is raw-count hysteresis: the sample stays above an upper watermark, or below a lower watermark, for a programmed number of consecutive periods. The second is the updated average landing above or below its own pair of watermarks. Each condition has its own enable bit. The interrupt output is raised while any enabled flag is set. Software clears flags by writing ones to them. A one-bit global status word mirrors the channel's interrupt.

Top module: `busload_monitor`

## Requirements
- R1: After reset, the period register (address 0x04) reads 11, meaning 12 ms. Control, average (0x60), channel status (0x64) and global status (0x00) all read 0. `irq_o` is low.
- R2: A sampling period ends on the (P+1)-th tick pulse, where P is the period register value. Tick pulses are counted only while both control bit 31 (channel on) and bit 18 (periodic sampling on) are set. Ticks arriving at any other time are ignored, and clearing either bit clears the tick count.
- R3: While the channel is on, every activity pulse adds the weight register (0x58, reset value 1024) to the accumulator. The accumulator saturates at 2^32-1. The period's sample is the accumulated value. A pulse that arrives in the same cycle a period closes is counted in the next period.
- R4: At each period end, the average (read at 0x60) becomes avg + ((sample - avg) >>> (K+1)). The arithmetic is signed, and K is control field [12:10]. A write to the seed register (0x4C) loads the average directly. The average changes at no other time.
- R5: Status bit 31 sets once the sample has been strictly greater than the upper watermark (0x44) for N+1 periods in a row, where N is control field [28:26]. Any period that fails the comparison restarts the run. Setting the flag also restarts the run. This needs control bit 30 set.
- R6: Status bit 30 sets once the sample has been strictly less than the lower watermark (0x48) for N+1 periods in a row, where N is control field [25:23]. The run restarts in the same ways as in R5. This needs control bit 29 set.
- R7: At a period end, status bit 29 sets if the updated average is greater than the average-upper watermark (0x50). Status bit 28 sets if the updated average is less than the average-lower watermark (0x54). These need control bits 21 and 20 respectively.
- R8: A flag whose enable bit is clear never sets, even if its condition holds.
- R9: Status bits [31:28] are sticky. Writing a one to a status bit clears that bit. Writing zero bits leaves the other bits unchanged.
- R10: `irq_o` is the OR of the set status bits whose enable bit is set. Global status bit 0 reads the same value. Clearing an enable bit drops the interrupt and keeps the flag.
- R11: The control register reads back only its defined fields at their bit positions: bits 31, 30, 29, 21, 20 and 18, and fields [28:26], [25:23] and [12:10]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| event_i | input | 1 | Activity pulse, one weight per high cycle |
| tick_i | input | 1 | Millisecond tick, one cycle wide |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that tick pulses are one cycle wide. They also assume that a register write is a single-cycle strobe, and that the seed is written only while sampling is stopped or between period ends. Under these assumptions, the average can change only at a period end or on a seed write, and a flag can rise only in the cycle after a period closes. The stimulus follows these assumptions. It toggles inputs only on the falling edge and keeps every pulse one cycle long. It spaces ticks with an idle cycle between them, so that activity pulses never fall in the cycle a period closes. It clears the control register before each scenario, so that run counters and the timer start from zero.

// File: rtl/busload_pkg.sv
package busload_pkg;
  localparam int DW     = 32;
  localparam int ADDR_W = 7;
  localparam int NUM_W  = 3;
  localparam int K_W    = 3;

  localparam logic [ADDR_W-1:0] A_GSTAT  = 7'h00;
  localparam logic [ADDR_W-1:0] A_PERIOD = 7'h04;
  localparam logic [ADDR_W-1:0] A_CTRL   = 7'h40;
  localparam logic [ADDR_W-1:0] A_UPWM   = 7'h44;
  localparam logic [ADDR_W-1:0] A_LOWM   = 7'h48;
  localparam logic [ADDR_W-1:0] A_SEED   = 7'h4C;
  localparam logic [ADDR_W-1:0] A_AUPWM  = 7'h50;
  localparam logic [ADDR_W-1:0] A_ALOWM  = 7'h54;
  localparam logic [ADDR_W-1:0] A_WEIGHT = 7'h58;
  localparam logic [ADDR_W-1:0] A_AVG    = 7'h60;
  localparam logic [ADDR_W-1:0] A_STAT   = 7'h64;

  localparam int B_EN     = 31;
  localparam int B_UPEN   = 30;
  localparam int B_DNEN   = 29;
  localparam int B_UPNUM  = 26;
  localparam int B_DNNUM  = 23;
  localparam int B_AUPEN  = 21;
  localparam int B_ADNEN  = 20;
  localparam int B_PEREN  = 18;
  localparam int B_K      = 10;
  localparam int B_STAT   = 28;  // status flags occupy [31:28]

  typedef struct packed {
    logic             en;
    logic             up_en;
    logic             dn_en;
    logic [NUM_W-1:0] up_num;
    logic [NUM_W-1:0] dn_num;
    logic             aup_en;
    logic             adn_en;
    logic             per_en;
    logic [K_W-1:0]   k;
  } ctrl_t;

  function automatic logic [DW-1:0] ctrl_pack(ctrl_t c);
    logic [DW-1:0] r;
    r = '0;
    r[B_EN]              = c.en;
    r[B_UPEN]            = c.up_en;
    r[B_DNEN]            = c.dn_en;
    r[B_UPNUM +: NUM_W]  = c.up_num;
    r[B_DNNUM +: NUM_W]  = c.dn_num;
    r[B_AUPEN]           = c.aup_en;
    r[B_ADNEN]           = c.adn_en;
    r[B_PEREN]           = c.per_en;
    r[B_K +: K_W]        = c.k;
    return r;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DW-1:0] w);
    ctrl_t c;
    c.en     = w[B_EN];
    c.up_en  = w[B_UPEN];
    c.dn_en  = w[B_DNEN];
    c.up_num = w[B_UPNUM +: NUM_W];
    c.dn_num = w[B_DNNUM +: NUM_W];
    c.aup_en = w[B_AUPEN];
    c.adn_en = w[B_ADNEN];
    c.per_en = w[B_PEREN];
    c.k      = w[B_K +: K_W];
    return c;
  endfunction
endpackage

// File: rtl/busload_regs.sv
module busload_regs
  import busload_pkg::*;
#(
  parameter int          PER_W      = 8,
  parameter int          DEF_PERIOD = 11,
  parameter logic [31:0] DEF_WEIGHT = 32'd1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [3:0]        st_i,
  input  logic [DW-1:0]     avg_i,
  input  logic              irq_i,
  output ctrl_t             ctrl_o,
  output logic [PER_W-1:0]  period_o,
  output logic [DW-1:0]     up_wm_o,
  output logic [DW-1:0]     lo_wm_o,
  output logic [DW-1:0]     aup_wm_o,
  output logic [DW-1:0]     alo_wm_o,
  output logic [DW-1:0]     weight_o,
  output logic              seed_we_o,
  output logic [DW-1:0]     seed_o,
  output logic [3:0]        st_clr_o
);
  logic [DW-1:0] seed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      period_o <= PER_W'(DEF_PERIOD);
      up_wm_o  <= '0;
      lo_wm_o  <= '0;
      aup_wm_o <= '0;
      alo_wm_o <= '0;
      weight_o <= DEF_WEIGHT;
      seed_q   <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_CTRL:   ctrl_o   <= ctrl_unpack(wdata_i);
        A_PERIOD: period_o <= wdata_i[PER_W-1:0];
        A_UPWM:   up_wm_o  <= wdata_i;
        A_LOWM:   lo_wm_o  <= wdata_i;
        A_AUPWM:  aup_wm_o <= wdata_i;
        A_ALOWM:  alo_wm_o <= wdata_i;
        A_WEIGHT: weight_o <= wdata_i;
        A_SEED:   seed_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign seed_we_o = we_i && (addr_i == A_SEED);
  assign seed_o    = wdata_i;
  assign st_clr_o  = (we_i && addr_i == A_STAT) ? wdata_i[B_STAT +: 4] : 4'b0;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_GSTAT:  rdata_o = {{(DW-1){1'b0}}, irq_i};
      A_PERIOD: rdata_o = {{(DW-PER_W){1'b0}}, period_o};
      A_CTRL:   rdata_o = ctrl_pack(ctrl_o);
      A_UPWM:   rdata_o = up_wm_o;
      A_LOWM:   rdata_o = lo_wm_o;
      A_SEED:   rdata_o = seed_q;
      A_AUPWM:  rdata_o = aup_wm_o;
      A_ALOWM:  rdata_o = alo_wm_o;
      A_WEIGHT: rdata_o = weight_o;
      A_AVG:    rdata_o = avg_i;
      A_STAT:   rdata_o = {st_i, {B_STAT{1'b0}}};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/busload_timer.sv
module busload_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             period_end_o
);
  logic [PER_W-1:0] ms_q;
  logic             last_ms;

  assign last_ms      = ms_q >= period_i;
  assign period_end_o = run_i && tick_i && last_ms;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ms_q <= '0;
    else if (!run_i) ms_q <= '0;
    else if (tick_i) ms_q <= last_ms ? '0 : ms_q + 1'b1;
  end
endmodule

// File: rtl/busload_avg.sv
module busload_avg
  import busload_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           event_i,
  input  logic [DW-1:0]  weight_i,
  input  logic           period_end_i,
  input  logic [K_W-1:0] k_i,
  input  logic           seed_we_i,
  input  logic [DW-1:0]  seed_i,
  output logic [DW-1:0]  acc_o,
  output logic [DW-1:0]  avg_o,
  output logic [DW-1:0]  avg_nxt_o
);
  logic [DW:0]          sum;
  logic [DW-1:0]        acc_inc;
  logic [K_W:0]         sh;
  logic signed [DW+1:0] diff, step, nxt;

  assign sum     = {1'b0, acc_o} + {1'b0, weight_i};
  assign acc_inc = sum[DW] ? '1 : sum[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_o <= '0;
    else if (!en_i)        acc_o <= '0;
    else if (period_end_i) acc_o <= event_i ? weight_i : '0;
    else if (event_i)      acc_o <= acc_inc;
  end

  assign sh        = {1'b0, k_i} + 1'b1;
  assign diff      = $signed({2'b00, acc_o}) - $signed({2'b00, avg_o});
  assign step      = diff >>> sh;
  assign nxt       = $signed({2'b00, avg_o}) + step;
  assign avg_nxt_o = nxt[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           avg_o <= '0;
    else if (seed_we_i)    avg_o <= seed_i;
    else if (period_end_i) avg_o <= avg_nxt_o;
  end
endmodule

// File: rtl/busload_wmark.sv
module busload_wmark
  import busload_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          period_end_i,
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] avg_nxt_i,
  input  logic [DW-1:0] up_wm_i,
  input  logic [DW-1:0] lo_wm_i,
  input  logic [DW-1:0] aup_wm_i,
  input  logic [DW-1:0] alo_wm_i,
  input  ctrl_t         ctrl_i,
  input  logic [3:0]    clr_i,
  output logic [3:0]    st_o,
  output logic          irq_o
);
  // index 0: above upper, index 1: below lower
  logic             hit   [2];
  logic             run_en[2];
  logic [NUM_W-1:0] need  [2];
  logic [1:0]       cons_set;
  logic [1:0]       avg_set;
  logic [3:0]       en_mask;

  assign hit[0]    = sample_i > up_wm_i;
  assign hit[1]    = sample_i < lo_wm_i;
  assign run_en[0] = ctrl_i.up_en;
  assign run_en[1] = ctrl_i.dn_en;
  assign need[0]   = ctrl_i.up_num;
  assign need[1]   = ctrl_i.dn_num;

  for (genvar g = 0; g < 2; g++) begin : g_cons
    logic [NUM_W-1:0] cnt_q;
    logic             done;
    assign done        = cnt_q == need[g];
    assign cons_set[g] = run_en[g] && period_end_i && hit[g] && done;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (!run_en[g])   cnt_q <= '0;
      else if (period_end_i) cnt_q <= (!hit[g] || done) ? '0 : cnt_q + 1'b1;
    end
  end

  assign avg_set[1] = ctrl_i.aup_en && period_end_i && (avg_nxt_i > aup_wm_i);
  assign avg_set[0] = ctrl_i.adn_en && period_end_i && (avg_nxt_i < alo_wm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= '0;
    else         st_o <= (st_o & ~clr_i) | {cons_set[0], cons_set[1], avg_set};
  end

  assign en_mask = {ctrl_i.up_en, ctrl_i.dn_en, ctrl_i.aup_en, ctrl_i.adn_en};
  assign irq_o   = |(st_o & en_mask);
endmodule

// File: rtl/busload_monitor.sv
module busload_monitor
  import busload_pkg::*;
#(
  parameter int          PER_W      = 8,
  parameter int          DEF_PERIOD = 11,
  parameter logic [31:0] DEF_WEIGHT = 32'd1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              event_i,
  input  logic              tick_i,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [PER_W-1:0] period;
  logic [DW-1:0]    up_wm, lo_wm, aup_wm, alo_wm, weight, seed;
  logic [DW-1:0]    acc_q, avg_q, avg_nxt;
  logic [3:0]       st_q, st_clr;
  logic             seed_we, period_end, ch_en, run;

  assign ch_en = ctrl.en;
  assign run   = ctrl.en && ctrl.per_en;

  busload_regs #(
    .PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD), .DEF_WEIGHT(DEF_WEIGHT)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .st_i(st_q), .avg_i(avg_q), .irq_i(irq_o),
    .ctrl_o(ctrl), .period_o(period),
    .up_wm_o(up_wm), .lo_wm_o(lo_wm), .aup_wm_o(aup_wm), .alo_wm_o(alo_wm),
    .weight_o(weight), .seed_we_o(seed_we), .seed_o(seed), .st_clr_o(st_clr)
  );

  busload_timer #(.PER_W(PER_W)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .tick_i, .period_i(period), .period_end_o(period_end)
  );

  busload_avg u_avg (
    .clk_i, .rst_ni, .en_i(ch_en), .event_i, .weight_i(weight),
    .period_end_i(period_end), .k_i(ctrl.k), .seed_we_i(seed_we), .seed_i(seed),
    .acc_o(acc_q), .avg_o(avg_q), .avg_nxt_o(avg_nxt)
  );

  busload_wmark u_wmark (
    .clk_i, .rst_ni, .period_end_i(period_end), .sample_i(acc_q), .avg_nxt_i(avg_nxt),
    .up_wm_i(up_wm), .lo_wm_i(lo_wm), .aup_wm_i(aup_wm), .alo_wm_i(alo_wm),
    .ctrl_i(ctrl), .clr_i(st_clr), .st_o(st_q), .irq_o
  );
endmodule

// File: rtl/busload_monitor_chk.sv
module busload_monitor_chk
  import busload_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              tick_i,
  input logic              irq_o,
  input logic [3:0]        st_q,
  input logic              period_end,
  input logic [DW-1:0]     avg_q,
  input logic [DW-1:0]     acc_q,
  input logic              ch_en,
  input logic              seed_we
);
  AST_PERIOD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |-> tick_i); // R2

  AST_ACC_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_en && !period_end) |=> acc_q >= $past(acc_q)); // R3

  AST_AVG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!period_end && !seed_we) |=> $stable(avg_q)); // R4

  AST_UPFLAG_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[3]) |-> $past(period_end)); // R5

  AST_DNFLAG_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[2]) |-> $past(period_end)); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == A_STAT) |=> (($past(st_q) & ~st_q) == 4'b0)); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (st_q != 4'b0)); // R10
endmodule

bind busload_monitor busload_monitor_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .tick_i(tick_i), .irq_o(irq_o), .st_q(st_q), .period_end(period_end),
  .avg_q(avg_q), .acc_q(acc_q), .ch_en(ch_en), .seed_we(seed_we)
);

// File: tb/tb_busload_monitor.sv
module tb_busload_monitor;
  localparam logic [6:0] A_GSTAT = 7'h00, A_PER = 7'h04, A_CTRL = 7'h40, A_UP = 7'h44,
                         A_LO = 7'h48, A_SEED = 7'h4C, A_AUP = 7'h50, A_ALO = 7'h54,
                         A_WGT = 7'h58, A_AVG = 7'h60, A_STAT = 7'h64;
  localparam logic [31:0] C_EN = 32'h8000_0000, C_UP = 32'h4000_0000, C_DN = 32'h2000_0000,
                          C_AUP = 32'h0020_0000, C_ADN = 32'h0010_0000, C_PER = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ev = 1'b0;
  logic        tick = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cur_per = 11;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  busload_monitor dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .event_i(ev), .tick_i(tick), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == A_PER) cur_per = int'(d[7:0]);
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_events(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ev = 1'b1;
      @(negedge clk) ev = 1'b0;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic period_with(int n);
    pulse_events(n);
    ticks(cur_per + 1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_PER, d);   chk("R1 period", d, 32'd11);
    rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
    rd(A_AVG, d);   chk("R1 avg", d, 32'h0);
    rd(A_STAT, d);  chk("R1 status", d, 32'h0);
    rd(A_GSTAT, d); chk("R1 global", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] d, v;
    v = C_EN | C_UP | C_DN | (32'd5 << 26) | (32'd6 << 23) | C_AUP | C_ADN | C_PER | (32'd3 << 10);
    wr(A_CTRL, v);
    rd(A_CTRL, d); chk("R11 fields", d, v);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R11 undefined bits", d, 32'hFFB4_1C00);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_period();
    logic [31:0] d;
    wr(A_PER, 32'd2);
    rd(A_WGT, d); chk("R3 weight default", d, 32'd1024);
    wr(A_SEED, 32'd0);
    wr(A_CTRL, C_EN | C_PER);
    pulse_events(4);
    ticks(2);
    rd(A_AVG, d); chk("R2 no close before P+1 ticks", d, 32'd0);
    ticks(1);
    rd(A_AVG, d); chk("R2 R4 close on P+1 tick", d, 32'd2048);
    wr(A_CTRL, C_EN);
    pulse_events(3);
    ticks(6);
    rd(A_AVG, d); chk("R2 ticks ignored without periodic", d, 32'd2048);
    wr(A_CTRL, C_EN | C_PER);
    ticks(3);
    rd(A_AVG, d); chk("R3 accumulate across stop", d, 32'd2560);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_avg_k();
    logic [31:0] d;
    wr(A_SEED, 32'd1000);
    rd(A_AVG, d);  chk("R4 seed loads average", d, 32'd1000);
    rd(A_SEED, d); chk("R4 seed readback", d, 32'd1000);
    wr(A_CTRL, C_EN | C_PER | (32'd2 << 10));
    period_with(10);
    rd(A_AVG, d); chk("R4 K=2 rise", d, 32'd2155);
    period_with(0);
    rd(A_AVG, d); chk("R4 K=2 negative step", d, 32'd1885);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    wr(A_WGT, 32'hFFFF_FFFF);
    wr(A_SEED, 32'hFFFF_FFFF);
    wr(A_CTRL, C_EN | C_PER);
    period_with(2);
    rd(A_AVG, d); chk("R3 saturation", d, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h0);
    wr(A_WGT, 32'd1024);
  endtask

  task automatic t_cons_up();
    logic [31:0] d;
    wr(A_UP, 32'd1000);
    wr(A_LO, 32'd0);
    wr(A_CTRL, C_EN | C_PER | C_UP | (32'd1 << 26));
    period_with(1);
    rd(A_STAT, d); chk("R5 one period short", d, 32'h0);
    period_with(0);
    period_with(1);
    rd(A_STAT, d); chk("R5 run broken", d, 32'h0);
    period_with(1);
    rd(A_STAT, d); chk("R5 flag after two", d, 32'h8000_0000);
    chk("R10 irq up", {31'b0, irq}, 32'h1);
    rd(A_GSTAT, d); chk("R10 global status", d, 32'h1);
    wr(A_STAT, 32'h8000_0000);
    rd(A_STAT, d); chk("R9 w1c", d, 32'h0);
    chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
    period_with(1);
    rd(A_STAT, d); chk("R5 restart after flag", d, 32'h0);
    period_with(1);
    rd(A_STAT, d); chk("R5 second flag", d, 32'h8000_0000);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_cons_dn();
    logic [31:0] d;
    wr(A_UP, 32'hFFFF_FFFF);
    wr(A_LO, 32'd5000);
    wr(A_CTRL, C_EN | C_PER | C_DN | (32'd2 << 23));
    period_with(0);
    period_with(0);
    rd(A_STAT, d); chk("R6 two of three", d, 32'h0);
    period_with(0);
    rd(A_STAT, d); chk("R6 flag after three", d, 32'h4000_0000);
    wr(A_STAT, 32'h8000_0000);
    rd(A_STAT, d); chk("R9 other bit kept", d, 32'h4000_0000);
    chk("R10 irq dn", {31'b0, irq}, 32'h1);
    wr(A_CTRL, C_EN | C_PER);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    rd(A_STAT, d); chk("R10 flag kept when masked", d, 32'h4000_0000);
    wr(A_STAT, 32'h4000_0000);
    rd(A_STAT, d); chk("R9 clear bit30", d, 32'h0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_avg_flags();
    logic [31:0] d;
    wr(A_AUP, 32'd1000);
    wr(A_ALO, 32'd0);
    wr(A_SEED, 32'd0);
    wr(A_CTRL, C_EN | C_PER | C_AUP);
    period_with(4);
    rd(A_STAT, d); chk("R7 avg above", d, 32'h2000_0000);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_AUP, 32'hFFFF_FFFF);
    wr(A_ALO, 32'd5000);
    wr(A_CTRL, C_EN | C_PER | C_ADN);
    period_with(0);
    rd(A_AVG, d);  chk("R4 decay", d, 32'd1024);
    rd(A_STAT, d); chk("R7 avg below", d, 32'h1000_0000);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(A_UP, 32'd0);
    wr(A_LO, 32'hFFFF_FFFF);
    wr(A_AUP, 32'd0);
    wr(A_ALO, 32'hFFFF_FFFF);
    wr(A_CTRL, C_EN | C_PER);
    period_with(2);
    period_with(2);
    rd(A_STAT, d); chk("R8 disabled flags stay clear", d, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_fields();
    t_period();
    t_avg_k();
    t_saturate();
    t_cons_up();
    t_cons_dn();
    t_avg_flags();
    t_enables();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule